// File: doc/BRIEF.md
# Two-Level Branch Speculation Controller

This block sits beside the decode stage of a simple in-order front end. It keeps track of conditional branches whose direction was guessed because their condition data was not ready, and it allows at most two of them to be unresolved at once. Each outstanding branch holds one of two slots. Each decoded instruction is told which slots it depends on, through a 2-bit mask. From that mask follow its rights: it may be issued and retired, issued but held back from retirement, or only fetched.

A third branch that arrives while both slots are held is refused, and fetch stalls until a slot frees. A resolve port reports a branch by its slot tag, with a mispredict flag and the corrected target. When the guess was right, the slot is released and dependent instructions lose that dependency. If that branch was the older one, fetch-only instructions may now execute. When the guess was wrong, the block emits one-cycle flush and redirect pulses and a kill mask naming every slot whose dependants must be discarded. Wrong-path decodes are refused while the purge is under way.

Top module: `spec_guard`

## Requirements
- R1: After reset no slot is held, every pulse output is low, and a decoded instruction gets mask 2'b00 with both execute and retire rights.
- R2: A decoded branch that is accepted takes the lowest-numbered free slot (dec_br_tag = 0 when slot 0 is free, else 1). Bit i of dec_spec_mask is set when slot i is held and is not being resolved correctly in the same cycle.
- R3: An instruction with mask 2'b00 gets dec_exec_ok=1 and dec_retire_ok=1. With exactly one mask bit set it gets dec_exec_ok=1 and dec_retire_ok=0.
- R4: An instruction with both mask bits set is fetch-only: dec_exec_ok=0 and dec_retire_ok=0.
- R5: A valid branch decoded while both slots are held raises fetch_stall and is not accepted. A non-branch instruction in the same state is accepted.
- R6: A correct resolve of a held slot raises bit tag of slot_clear for one cycle on the following cycle and frees that slot.
- R7: A correct resolve of the older slot while both are held raises release_pulse on the following cycle, and the younger slot becomes the older.
- R8: A mispredicting resolve of a held slot raises flush_pulse and redirect_valid on the following cycle, with redirect_addr equal to the supplied target. flush_kill holds the resolved slot plus the younger slot when the resolved one was the older. Killed slots are freed. The address reads zero in cycles without a redirect.
- R9: A decode presented in the same cycle as a mispredicting resolve, or in the cycle of flush_pulse, is not accepted and allocates no slot.
- R10: A resolve whose tag names a slot that is not held is ignored: no pulse follows and the slot state is unchanged.
- R11: In a cycle where a held slot resolves correctly, a new branch may be accepted into the other free slot. The decoded instruction's mask already excludes the resolving slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | An instruction is presented at decode |
| dec_is_branch | input | 1 | The presented instruction is a predicted conditional branch |
| res_valid | input | 1 | A branch outcome is reported |
| res_tag | input | 1 | Slot of the reported branch |
| res_mispredict | input | 1 | The reported branch was guessed wrongly |
| res_target | input | ADDR_W | Corrected fetch address for a misprediction |
| dec_accept | output | 1 | The presented instruction is taken this cycle |
| dec_exec_ok | output | 1 | The instruction may be issued for execution |
| dec_retire_ok | output | 1 | The instruction may retire without waiting |
| dec_spec_mask | output | 2 | Slots the instruction depends on |
| dec_br_tag | output | 1 | Slot given to an accepted branch |
| fetch_stall | output | 1 | Fetch must hold: a third branch is waiting |
| flush_pulse | output | 1 | One-cycle purge request |
| flush_kill | output | 2 | Slots whose dependants are discarded |
| redirect_valid | output | 1 | One-cycle fetch restart request |
| redirect_addr | output | ADDR_W | Restart address |
| slot_clear | output | 2 | Slots resolved correctly; dependants drop that bit |
| release_pulse | output | 1 | Fetch-only instructions may now execute |

## Verification
A resolve and a decode can land in the same cycle, and the outcome of each depends on the other. A correct resolve must already be missing from the new instruction's mask, and its slot may be handed out at once. A mispredict must refuse the decode. The bench provokes both pairings on purpose, and a mixed random phase reaches them often. A per-cycle reference model, built from slot flags and an age index, judges the accept, tag, mask and pulse outputs at each cycle.

// File: rtl/spg_pkg.sv
package spg_pkg;
  localparam int SLOTS = 2;
  typedef logic [SLOTS-1:0] slot_mask_t;

  // number of outstanding branches an instruction depends on
  function automatic logic [1:0] spec_depth(slot_mask_t m);
    return 2'($countones(m));
  endfunction

  // one-hot mask for a slot tag
  function automatic slot_mask_t tag_bit(logic t);
    return t ? 2'b10 : 2'b01;
  endfunction

  // lowest free slot; meaningful only when one is free
  function automatic logic first_free(slot_mask_t held);
    return held[0];
  endfunction

  // slots purged by a wrong guess on slot t
  function automatic slot_mask_t purge_set(logic t, logic older, slot_mask_t held);
    return (t == older) ? held : tag_bit(t);
  endfunction
endpackage

// File: rtl/spg_slots.sv
module spg_slots
  import spg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alloc_en,
  input  logic       alloc_tag,
  input  slot_mask_t kill_now,
  input  slot_mask_t clear_now,
  output slot_mask_t held_q,
  output logic       older_q
);
  slot_mask_t held_d;
  logic       older_d;

  always_comb begin
    held_d = held_q & ~kill_now & ~clear_now;
    if (alloc_en) held_d = held_d | tag_bit(alloc_tag);
    // with both held the survivor keeps its age; otherwise the lone slot is older
    older_d = (&held_d) ? older_q : held_d[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= '0;
      older_q <= 1'b0;
    end else begin
      held_q  <= held_d;
      older_q <= older_d;
    end
  end

  a_r2_alloc_to_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !held_q[alloc_tag]);
endmodule

// File: rtl/spg_resolve.sv
module spg_resolve
  import spg_pkg::*;
(
  input  logic       res_valid,
  input  logic       res_tag,
  input  logic       res_mispredict,
  input  slot_mask_t held,
  input  logic       older,
  output logic       bad_now,
  output logic       good_now,
  output slot_mask_t kill_now,
  output slot_mask_t clear_now,
  output logic       release_now
);
  logic hit;

  always_comb begin
    hit         = res_valid && held[res_tag];
    bad_now     = hit && res_mispredict;
    good_now    = hit && !res_mispredict;
    kill_now    = bad_now  ? purge_set(res_tag, older, held) : '0;
    clear_now   = good_now ? tag_bit(res_tag) : '0;
    release_now = good_now && (res_tag == older) && (&held);
  end
endmodule

// File: rtl/spg_decode.sv
module spg_decode
  import spg_pkg::*;
(
  input  logic       dec_valid,
  input  logic       dec_is_branch,
  input  slot_mask_t held,
  input  slot_mask_t clear_now,
  input  logic       bad_now,
  input  logic       flushing,
  output logic       accept,
  output logic       stall,
  output slot_mask_t mask,
  output logic       exec_ok,
  output logic       retire_ok,
  output logic       br_tag,
  output logic       alloc_en
);
  logic full;
  logic purge_block;

  always_comb begin
    full        = &held;
    purge_block = bad_now || flushing;
    stall       = dec_valid && dec_is_branch && full;
    accept      = dec_valid && !purge_block && !stall;
    mask        = held & ~clear_now;
    exec_ok     = spec_depth(mask) <= 2'd1;
    retire_ok   = spec_depth(mask) == 2'd0;
    br_tag      = first_free(held);
    alloc_en    = accept && dec_is_branch;
  end
endmodule

// File: rtl/spec_guard.sv
module spec_guard
  import spg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic              dec_is_branch,
  input  logic              res_valid,
  input  logic              res_tag,
  input  logic              res_mispredict,
  input  logic [ADDR_W-1:0] res_target,
  output logic              dec_accept,
  output logic              dec_exec_ok,
  output logic              dec_retire_ok,
  output logic [1:0]        dec_spec_mask,
  output logic              dec_br_tag,
  output logic              fetch_stall,
  output logic              flush_pulse,
  output logic [1:0]        flush_kill,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic [1:0]        slot_clear,
  output logic              release_pulse
);
  slot_mask_t held_q, kill_now, clear_now, mask_w;
  logic older_q, bad_now, good_now, release_now, alloc_en, alloc_tag;

  spg_resolve u_res (
    .res_valid(res_valid), .res_tag(res_tag), .res_mispredict(res_mispredict),
    .held(held_q), .older(older_q), .bad_now(bad_now), .good_now(good_now),
    .kill_now(kill_now), .clear_now(clear_now), .release_now(release_now)
  );

  spg_decode u_dec (
    .dec_valid(dec_valid), .dec_is_branch(dec_is_branch), .held(held_q),
    .clear_now(clear_now), .bad_now(bad_now), .flushing(flush_pulse),
    .accept(dec_accept), .stall(fetch_stall), .mask(mask_w),
    .exec_ok(dec_exec_ok), .retire_ok(dec_retire_ok), .br_tag(alloc_tag),
    .alloc_en(alloc_en)
  );

  spg_slots u_slots (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_tag(alloc_tag),
    .kill_now(kill_now), .clear_now(clear_now), .held_q(held_q), .older_q(older_q)
  );

  assign dec_spec_mask = mask_w;
  assign dec_br_tag    = alloc_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_pulse    <= 1'b0;
      flush_kill     <= '0;
      redirect_valid <= 1'b0;
      redirect_addr  <= '0;
      slot_clear     <= '0;
      release_pulse  <= 1'b0;
    end else begin
      flush_pulse    <= bad_now;
      flush_kill     <= kill_now;
      redirect_valid <= bad_now;
      redirect_addr  <= bad_now ? res_target : '0;
      slot_clear     <= clear_now;
      release_pulse  <= release_now;
    end
  end

  // R6 / R8: a slot named by a clear or kill pulse is no longer held
  a_r6_cleared_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_clear & held_q) == 2'b00);
  a_r8_killed_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_kill & held_q) == 2'b00);
  a_r8_kill_with_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> (flush_kill != 2'b00) && redirect_valid);
  a_r7_release_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |-> $past(&held_q));
  a_r10_ghost_resolve_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !held_q[res_tag]) |=> !flush_pulse && (slot_clear == 2'b00));
endmodule

// File: tb/spec_guard_test.sv
module spec_guard_test;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic dv = 0, br = 0, rv = 0, rt = 0, rm = 0;
  logic [AW-1:0] tg = '0;
  logic acc, exo, rto, btag, stl, fl, rdv, rel;
  logic [1:0] msk, kil, clr;
  logic [AW-1:0] radr;

  always #5 clk = ~clk;

  spec_guard #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dv), .dec_is_branch(br),
    .res_valid(rv), .res_tag(rt), .res_mispredict(rm), .res_target(tg),
    .dec_accept(acc), .dec_exec_ok(exo), .dec_retire_ok(rto),
    .dec_spec_mask(msk), .dec_br_tag(btag), .fetch_stall(stl),
    .flush_pulse(fl), .flush_kill(kil), .redirect_valid(rdv),
    .redirect_addr(radr), .slot_clear(clr), .release_pulse(rel)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;
  string phase = "R1";

  // reference model: busy flags, index of the older slot, pending pulses
  bit busy[2];
  int oldest = 0;
  int q_flush = 0, q_kill = 0, q_clear = 0, q_rel = 0;
  logic [AW-1:0] q_addr = '0;

  task automatic cmp(string f, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", phase, f, act, exp);
    end
  endtask

  task automatic step(bit d, bit b, bit r, bit t, bit m, logic [AW-1:0] target);
    int deps, emask, etag, nk, nc, nr;
    bit hit, wrong, right, full, eacc;
    @(negedge clk);
    dv = d; br = b; rv = r; rt = t; rm = m; tg = target;
    #1;
    hit   = r && busy[t];
    wrong = hit && m;
    right = hit && !m;
    full  = busy[0] && busy[1];
    deps = 0; emask = 0;
    for (int i = 0; i < 2; i++)
      if (busy[i] && !(right && t == i)) begin deps++; emask += (1 << i); end
    etag = busy[0] ? 1 : 0;
    eacc = d && (q_flush == 0) && !wrong && !(b && full);
    cmp("accept", acc, eacc);
    cmp("stall", stl, d && b && full);
    cmp("mask", msk, emask);
    cmp("exec_ok", exo, deps <= 1);
    cmp("retire_ok", rto, deps == 0);
    cmp("br_tag", btag, etag);
    cmp("flush", fl, q_flush);
    cmp("redirect", rdv, q_flush);
    cmp("redirect_addr", radr, q_addr);
    cmp("kill", kil, q_kill);
    cmp("clear", clr, q_clear);
    cmp("release", rel, q_rel);
    // advance the model
    nk = 0;
    if (wrong) nk = (t == oldest) ? ((busy[0] ? 1 : 0) + (busy[1] ? 2 : 0)) : (1 << t);
    nc = right ? (1 << t) : 0;
    nr = (right && t == oldest && full) ? 1 : 0;
    for (int i = 0; i < 2; i++) if (((nk | nc) >> i) & 1) busy[i] = 0;
    if (eacc && b) busy[etag] = 1;
    if (!(busy[0] && busy[1])) oldest = busy[1] ? 1 : 0;
    q_flush = wrong; q_kill = nk; q_clear = nc; q_rel = nr;
    q_addr = wrong ? target : '0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1"; step(1, 0, 0, 0, 0, 0);          // reset state
    phase = "R3"; step(1, 0, 0, 0, 0, 0);
    phase = "R2"; step(1, 1, 0, 0, 0, 0);          // branch A -> slot 0
    phase = "R3"; step(1, 0, 0, 0, 0, 0);          // one level
    phase = "R2"; step(1, 1, 0, 0, 0, 0);          // branch B -> slot 1
    phase = "R4"; step(1, 0, 0, 0, 0, 0);          // fetch only
    phase = "R5"; step(1, 1, 0, 0, 0, 0);          // third branch stalls
    phase = "R5"; step(1, 0, 0, 0, 0, 0);
    phase = "R11"; step(1, 0, 1, 0, 0, 0);         // older resolves right with decode
    phase = "R7"; step(0, 0, 0, 0, 0, 0);          // release pulse
    phase = "R11"; step(1, 1, 1, 1, 0, 0);         // slot 1 right, branch takes slot 0
    phase = "R6"; step(1, 1, 0, 0, 0, 0);          // clear seen, new branch slot 1
    phase = "R8"; step(1, 1, 1, 0, 1, 32'h0000_4A30); // older wrong: both killed
    phase = "R9"; step(1, 0, 0, 0, 0, 0);          // flush cycle refuses decode
    phase = "R8"; step(1, 1, 0, 0, 0, 0);
    phase = "R8"; step(1, 1, 0, 0, 0, 0);
    phase = "R8"; step(0, 0, 1, 1, 1, 32'h0000_1F00); // younger wrong only
    phase = "R8"; step(1, 0, 0, 0, 0, 0);
    phase = "R10"; step(1, 0, 1, 1, 0, 0);         // ghost resolve
    phase = "R10"; step(1, 0, 1, 1, 1, 32'hDEAD_0000);
    phase = "R10"; step(1, 0, 0, 0, 0, 0);
    phase = "R6"; step(0, 0, 1, 0, 0, 0);
    phase = "R6"; step(0, 0, 0, 0, 0, 0);
    phase = "mix R2 R5 R8 R9 R11";
    for (int k = 0; k < 3000; k++)
      step($urandom % 4 != 0, $urandom % 3 == 0, $urandom % 3 == 0,
           1'($urandom), $urandom % 3 == 0, $urandom);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule